// File: doc/BRIEF.md
# DRAM Traffic Event Counter Unit

This unit sits beside a DRAM controller and counts what the controller does. Four single-cycle pulse inputs report read bursts, write bursts, row activations and idle cycles. Each pulse feeds its own counter. A fifth counter measures elapsed time by advancing on every clock while counting runs. Software drives the unit through a small register bus. One command starts every counter together and another stops them together. A configuration register chooses which event counters take part. A clear register zeroes any chosen counters with one write.

Every counter is `CNT_W` bits wide, 32 by default. When any counter wraps from all ones to zero, every counter stops at once. This freeze keeps a consistent snapshot for software to read. A sticky bit records which counter wrapped, and an interrupt can be raised for it. Register reads are combinational and have no side effects, so software can poll the live counts while counting is under way.

Top module: `dram_evt_mon`

## Requirements
- R1: After reset the unit is stopped and irq is low. Every counter, the configuration, overflow status, interrupt enable and interrupt status read 0. Address 0x3FC reads the constant 0xA3C5DD01.
- R2: Writing control (0x000) with bit 0 set starts counting, and writing it with bit 1 set stops counting. If both bits are set in one write, the unit ends up stopped. Control always reads back 0.
- R3: Event counter n is at address 0x030 + 8·n, with n = 0 read, 1 write, 2 activate, 3 idle. It gains exactly 1 on each clock edge where its pulse input is high, configuration (0x004) bit n is 1, and counting runs.
- R4: The time counter at 0x020 gains 1 on every clock edge while counting runs, whatever the configuration holds.
- R5: A write to 0x00C with bit n (0 to 3) set zeroes event counter n, and bit 31 zeroes the time counter. A clear also drops that counter's overflow status bit. In the same cycle, a clear takes priority over an increment.
- R6: When a counter wraps from all ones to zero, its bit in overflow status (0x008) is set and stays set, using the same positions as the clear register. While any status bit is set, no counter changes. Clearing every wrapped counter lets counting resume.
- R7: A wrap also sets the bit in the same position of interrupt status (0x014). Writing 1 to a bit of 0x018 clears that bit. irq is high exactly when a set interrupt status bit is also set in interrupt enable (0x010). Only bits 0 to 3 and 31 are implemented.
- R8: Writes to the counter addresses, overflow status, interrupt status and the identification register change nothing.
- R9: Reading a counter while counting runs returns its live value and does not change it. Reads on consecutive cycles show consecutive counts.
- R10: Counters are CNT_W bits wide and read back zero-extended to 32 bits. A counter wraps after 2^CNT_W increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_read | input | 1 | Read burst event pulse |
| evt_write | input | 1 | Write burst event pulse |
| evt_activate | input | 1 | Row activation event pulse |
| evt_idle | input | 1 | Idle cycle event pulse |
| reg_addr | input | 12 | Register byte address, shared by reads and writes |
| reg_wen | input | 1 | Write strobe, one write per asserted cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest state to reach from the ports is a frozen unit whose overflow status is only partly cleared. Two counters must wrap on the same edge, and one of them must then be cleared while the other still holds the freeze. The bench builds the unit with 8-bit counters and holds the read pulse high with only that counter enabled. This makes the read counter and the time counter wrap together after 256 counting edges. The bench then clears the two status bits one write at a time. It checks that nothing moves until the second clear, and that both counters resume from zero after it.

// File: rtl/dme_pkg.sv
package dme_pkg;
  localparam int unsigned REG_AW   = 12;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned NUM_EV   = 4;
  localparam int unsigned NUM_CNT  = NUM_EV + 1;
  localparam int unsigned TIME_IDX = NUM_EV;
  localparam int unsigned TIME_BIT = 31;
  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_STOP  = 1;

  typedef logic [REG_AW-1:0] addr_t;
  typedef logic [REG_DW-1:0] word_t;

  localparam addr_t A_CTRL    = 12'h000;
  localparam addr_t A_CFG     = 12'h004;
  localparam addr_t A_OVF     = 12'h008;
  localparam addr_t A_CLR     = 12'h00C;
  localparam addr_t A_IEN     = 12'h010;
  localparam addr_t A_IST     = 12'h014;
  localparam addr_t A_ICLR    = 12'h018;
  localparam addr_t A_TIME    = 12'h020;
  localparam addr_t A_EV_BASE = 12'h030;
  localparam addr_t EV_STRIDE = 12'h008;
  localparam addr_t A_ID      = 12'h3FC;

  localparam word_t ID_VALUE  = 32'hA3C5DD01;

  // Register bit position owned by counter k (events low, time at the top).
  function automatic int unsigned bit_of(int unsigned k);
    return (k == TIME_IDX) ? TIME_BIT : k;
  endfunction

  // Gather the per-counter bits out of a register word.
  function automatic logic [NUM_CNT-1:0] pick_bits(word_t w);
    logic [NUM_CNT-1:0] r;
    for (int unsigned k = 0; k < NUM_CNT; k++) r[k] = w[bit_of(k)];
    return r;
  endfunction

  // Spread per-counter bits into their register positions.
  function automatic word_t place_bits(logic [NUM_CNT-1:0] v);
    word_t r;
    r = '0;
    for (int unsigned k = 0; k < NUM_CNT; k++) r[bit_of(k)] = v[k];
    return r;
  endfunction

  // Byte address of counter k.
  function automatic addr_t cnt_addr(int unsigned k);
    return (k == TIME_IDX) ? A_TIME : addr_t'(A_EV_BASE + addr_t'(k) * EV_STRIDE);
  endfunction
endpackage

// File: rtl/dme_counter.sv
module dme_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  // A wrap only counts when the clear did not win this cycle.
  assign wrap_o = inc_i && !clr_i && (cnt_q == ALL_ONES);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dme_ctrl.sv
module dme_ctrl
  import dme_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wen_i,
  input  addr_t              waddr_i,
  input  word_t              wdata_i,
  input  logic [NUM_CNT-1:0] wrap_i,
  output logic               count_en_o,
  output logic               frozen_o,
  output logic [NUM_EV-1:0]  cfg_o,
  output logic [NUM_CNT-1:0] clr_o,
  output logic [NUM_CNT-1:0] ovf_o,
  output logic [NUM_CNT-1:0] ien_o,
  output logic [NUM_CNT-1:0] ist_o,
  output logic               irq_o
);
  logic wr_ctrl, wr_cfg, wr_clr, wr_ien, wr_iclr;
  logic start_cmd, stop_cmd;
  logic run_q;
  logic [NUM_EV-1:0]  cfg_q;
  logic [NUM_CNT-1:0] ovf_q, ien_q, ist_q, ist_clr;

  // Write decode: one named strobe per writable register.
  assign wr_ctrl = wen_i && (waddr_i == A_CTRL);
  assign wr_cfg  = wen_i && (waddr_i == A_CFG);
  assign wr_clr  = wen_i && (waddr_i == A_CLR);
  assign wr_ien  = wen_i && (waddr_i == A_IEN);
  assign wr_iclr = wen_i && (waddr_i == A_ICLR);

  assign start_cmd = wr_ctrl && wdata_i[CMD_START];
  assign stop_cmd  = wr_ctrl && wdata_i[CMD_STOP];
  assign clr_o     = wr_clr  ? pick_bits(wdata_i) : '0;
  assign ist_clr   = wr_iclr ? pick_bits(wdata_i) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cfg_q <= '0;
      ovf_q <= '0;
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      if (stop_cmd)       run_q <= 1'b0;
      else if (start_cmd) run_q <= 1'b1;
      if (wr_cfg) cfg_q <= wdata_i[NUM_EV-1:0];
      if (wr_ien) ien_q <= pick_bits(wdata_i);
      ovf_q <= (ovf_q & ~clr_o) | wrap_i;
      ist_q <= (ist_q & ~ist_clr) | wrap_i;
    end
  end

  assign frozen_o   = |ovf_q;
  assign count_en_o = run_q && !frozen_o;
  assign cfg_o      = cfg_q;
  assign ovf_o      = ovf_q;
  assign ien_o      = ien_q;
  assign ist_o      = ist_q;
  assign irq_o      = |(ist_q & ien_q);

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !run_q);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !stop_cmd) |=> run_q);

  // R6
  wrap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> !count_en_o);

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_o && !wr_clr) |=> frozen_o);

  // R7
  ist_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> ((ist_q & $past(wrap_i)) == $past(wrap_i)));
endmodule

// File: rtl/dme_rdmux.sv
module dme_rdmux
  import dme_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  addr_t                      addr_i,
  input  logic [NUM_CNT-1:0][W-1:0]  cnt_i,
  input  logic [NUM_EV-1:0]          cfg_i,
  input  logic [NUM_CNT-1:0]         ovf_i,
  input  logic [NUM_CNT-1:0]         ien_i,
  input  logic [NUM_CNT-1:0]         ist_i,
  output word_t                      rdata_o
);
  word_t reg_word;
  word_t cnt_word;
  logic  cnt_hit;

  always_comb begin
    reg_word = '0;
    case (addr_i)
      A_CFG:   reg_word[NUM_EV-1:0] = cfg_i;
      A_OVF:   reg_word = place_bits(ovf_i);
      A_IEN:   reg_word = place_bits(ien_i);
      A_IST:   reg_word = place_bits(ist_i);
      A_ID:    reg_word = ID_VALUE;
      default: reg_word = '0;
    endcase
  end

  // Counters: zero-extend the selected CNT_W-bit value.
  always_comb begin
    cnt_word = '0;
    cnt_hit  = 1'b0;
    for (int unsigned k = 0; k < NUM_CNT; k++) begin
      if (addr_i == cnt_addr(k)) begin
        cnt_hit         = 1'b1;
        cnt_word[W-1:0] = cnt_i[k];
      end
    end
  end

  assign rdata_o = cnt_hit ? cnt_word : reg_word;
endmodule

// File: rtl/dram_evt_mon.sv
module dram_evt_mon
  import dme_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_read,
  input  logic        evt_write,
  input  logic        evt_activate,
  input  logic        evt_idle,
  input  logic [11:0] reg_addr,
  input  logic        reg_wen,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  logic [NUM_EV-1:0]              evt_vec;
  logic [NUM_CNT-1:0]             inc_vec, clr_vec, wrap_vec;
  logic [NUM_CNT-1:0]             ovf_vec, ien_vec, ist_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_bus;
  logic [NUM_EV-1:0]              cfg_vec;
  logic                           count_en, frozen;

  assign evt_vec = {evt_idle, evt_activate, evt_write, evt_read};

  dme_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wen_i      (reg_wen),
    .waddr_i    (reg_addr),
    .wdata_i    (reg_wdata),
    .wrap_i     (wrap_vec),
    .count_en_o (count_en),
    .frozen_o   (frozen),
    .cfg_o      (cfg_vec),
    .clr_o      (clr_vec),
    .ovf_o      (ovf_vec),
    .ien_o      (ien_vec),
    .ist_o      (ist_vec),
    .irq_o      (irq)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    if (k == TIME_IDX) begin : g_time
      assign inc_vec[k] = count_en;
    end else begin : g_evt
      assign inc_vec[k] = count_en && cfg_vec[k] && evt_vec[k];
    end
    dme_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_vec[k]),
      .inc_i  (inc_vec[k]),
      .cnt_o  (cnt_bus[k]),
      .wrap_o (wrap_vec[k])
    );
  end

  dme_rdmux #(.W(CNT_W)) u_rd (
    .addr_i  (reg_addr),
    .cnt_i   (cnt_bus),
    .cfg_i   (cfg_vec),
    .ovf_i   (ovf_vec),
    .ien_i   (ien_vec),
    .ist_i   (ist_vec),
    .rdata_o (reg_rdata)
  );

  // R6
  freeze_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !(|clr_vec)) |=> $stable(cnt_bus));

  // R4
  time_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clr_vec[TIME_IDX] && !wrap_vec[TIME_IDX])
      |=> (cnt_bus[TIME_IDX] != '0));

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && (reg_addr == A_TIME) && !count_en && !(|clr_vec))
      |=> $stable(cnt_bus[TIME_IDX]));
endmodule

// File: tb/sim_dram_evt_mon.sv
module sim_dram_evt_mon;
  localparam int unsigned W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ev = 4'h0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          vecs = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dram_evt_mon #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_read(ev[0]), .evt_write(ev[1]), .evt_activate(ev[2]), .evt_idle(ev[3]),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [11:0] ev_addr(int n);
    return 12'(12'h030 + 8 * n);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state and identification
    rchk("R1 ctrl", 12'h000, 32'h0);
    rchk("R1 cfg", 12'h004, 32'h0);
    rchk("R1 ovf", 12'h008, 32'h0);
    rchk("R1 ien", 12'h010, 32'h0);
    rchk("R1 ist", 12'h014, 32'h0);
    rchk("R1 time", 12'h020, 32'h0);
    for (int n = 0; n < 4; n++) rchk("R1 event", ev_addr(n), 32'h0);
    rchk("R1 id", 12'h3FC, 32'hA3C5DD01);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R3 R4 R10 sweep: every enable mask against every held pulse pattern.
    // start, 3 idle cycles, stop => 5 counting edges.
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        wr(12'h00C, 32'h8000000F);
        wr(12'h004, 32'(c));
        ev = 4'(p);
        wr(12'h000, 32'h1);
        idle(3);
        wr(12'h000, 32'h2);
        ev = 4'h0;
        rchk("R4 time", 12'h020, 32'd5);
        for (int n = 0; n < 4; n++)
          rchk("R3 event", ev_addr(n), (c[n] && p[n]) ? 32'd5 : 32'd0);
        rchk("R2 ctrl readback", 12'h000, 32'h0);
      end
    end

    // R2 start and stop in one write: stop wins
    wr(12'h00C, 32'h8000000F);
    wr(12'h000, 32'h3);
    idle(5);
    rchk("R2 both cmds", 12'h020, 32'h0);

    // R3 alternating pulses on the read input, only read counter enabled
    wr(12'h00C, 32'h8000000F);
    wr(12'h004, 32'h1);
    wr(12'h000, 32'h1);
    for (int j = 0; j < 10; j++) begin
      ev[0] = j[0];
      @(negedge clk);
    end
    ev = 4'h0;
    wr(12'h000, 32'h2);
    rchk("R3 alt read", ev_addr(0), 32'd5);
    rchk("R4 alt time", 12'h020, 32'd12);

    // R8 writes to read-only registers change nothing
    wr(12'h020, 32'hFF);
    wr(ev_addr(0), 32'hAA);
    wr(12'h008, 32'h8000000F);
    wr(12'h014, 32'h8000000F);
    wr(12'h3FC, 32'h0);
    rchk("R8 time", 12'h020, 32'd12);
    rchk("R8 event", ev_addr(0), 32'd5);
    rchk("R8 ovf", 12'h008, 32'h0);
    rchk("R8 ist", 12'h014, 32'h0);
    rchk("R8 id", 12'h3FC, 32'hA3C5DD01);

    // R9 live reads on consecutive cycles
    wr(12'h00C, 32'h8000000F);
    ev = 4'h1;
    wr(12'h000, 32'h1);
    idle(2);
    for (int j = 0; j < 3; j++) begin
      reg_addr = ev_addr(0);
      #1;
      v = reg_rdata;
      chk("R9 live", v, 32'(2 + j));
      @(negedge clk);
    end
    wr(12'h000, 32'h2);
    ev = 4'h0;

    // R5 clear beats increment on the same edge
    wr(12'h00C, 32'h8000000F);
    wr(12'h004, 32'hF);
    ev = 4'hF;
    wr(12'h000, 32'h1);
    idle(5);
    wr(12'h00C, 32'h80000000);
    rchk("R5 time cleared", 12'h020, 32'h0);
    rchk("R5 activate kept", ev_addr(2), 32'd7);
    wr(12'h000, 32'h2);
    ev = 4'h0;

    // R6 R7 R10 overflow, freeze, interrupt, partial then full release
    wr(12'h00C, 32'h8000000F);
    wr(12'h010, 32'h0);
    wr(12'h004, 32'h1);
    ev = 4'h1;
    wr(12'h000, 32'h1);
    idle(198);
    rchk("R10 time width", 12'h020, 32'd198);
    idle(80);
    rchk("R6 ovf", 12'h008, 32'h80000001);
    rchk("R7 ist", 12'h014, 32'h80000001);
    chk("R7 irq masked", {31'h0, irq}, 32'h0);
    rchk("R10 time wrapped", 12'h020, 32'h0);
    rchk("R10 read wrapped", ev_addr(0), 32'h0);
    idle(5);
    rchk("R6 time frozen", 12'h020, 32'h0);
    wr(12'h010, 32'h1);
    chk("R7 irq on", {31'h0, irq}, 32'h1);
    wr(12'h018, 32'h1);
    rchk("R7 ist after clear", 12'h014, 32'h80000000);
    chk("R7 irq off", {31'h0, irq}, 32'h0);
    wr(12'h010, 32'h80000000);
    chk("R7 irq time", {31'h0, irq}, 32'h1);
    wr(12'h018, 32'h80000000);
    chk("R7 irq time off", {31'h0, irq}, 32'h0);
    wr(12'h00C, 32'h1);
    rchk("R5 status bit dropped", 12'h008, 32'h80000000);
    idle(5);
    rchk("R6 still frozen time", 12'h020, 32'h0);
    rchk("R6 still frozen read", ev_addr(0), 32'h0);
    wr(12'h00C, 32'h80000000);
    rchk("R6 released", 12'h008, 32'h0);
    idle(4);
    rchk("R6 resume time", 12'h020, 32'd4);
    rchk("R6 resume read", ev_addr(0), 32'd4);
    wr(12'h000, 32'h2);
    ev = 4'h0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule